// File: doc/BRIEF.md
# Byte-Lane Memory Access Steering

This block sits between a processor's data port and a 32-bit memory built from four byte-wide lanes. It takes an access of one, two or four bytes at any byte address and turns it into a word address, a set of per-lane byte enables and lane-placed write data. On a read it takes the whole fetched word, picks out the requested bytes and returns them right-aligned and zero-extended. A configuration pin selects little-endian or big-endian byte order at run time, so the same storage serves either convention. Lane `i` always holds the byte whose address ends in `i`; only the mapping between data significance and address changes with the byte order.

The processor side is valid/ready. The processor raises `cpu_valid` with stable request fields and holds them until it sees `cpu_ready`. The transfer completes on the rising edge where both are high. An aligned request is captured in the cycle it is presented and goes to memory one cycle later. The memory side holds `mem_req` and its fields steady until a one-cycle `mem_ack`. `cpu_ready` is raised in that acknowledge cycle, and read data is valid in the same cycle. A misaligned request is refused: it is consumed at once with `cpu_misalign`, and the memory sees no request.

Top module: `lane_steer_top`

## Requirements
- R1: While reset is active and until the first request, `mem_req`, `cpu_ready` and `mem_be` are all 0.
- R2: `mem_word_addr` equals the byte address shifted right by two. `mem_req` rises the cycle after an aligned request is seen with `cpu_valid`, and holds its address, enables and data stable until `mem_ack`. It drops the cycle after the acknowledge.
- R3: In little-endian mode (`cfg_big_endian` = 0), data byte k (k = 0 least significant) of an n-byte write goes to lane (offset + k). Only lanes offset to offset + n − 1 have their `mem_be` bit set.
- R4: In big-endian mode (`cfg_big_endian` = 1), data byte k of an n-byte write goes to lane (offset + n − 1 − k). The enabled lanes are the same as in R3.
- R5: A little-endian read of n bytes returns lane (offset + k) in data byte k. All bytes from n upward are zero.
- R6: A big-endian read of n bytes returns lane (offset + n − 1 − k) in data byte k, zero-extended.
- R7: The size field is encoded as 00 = byte, 01 = halfword and 10 = word. A word access at offset 0 enables all four lanes, and in big-endian mode it reverses the byte order between the data and the lanes.
- R8: Three kinds of request are misaligned: a halfword at an odd address, a word at an address that is not a multiple of four, and size code 11. A misaligned request raises `cpu_misalign` and `cpu_ready` in the cycle it is presented. It issues no memory request and changes no memory byte.
- R9: For an aligned access, `cpu_ready` is high only in the `mem_ack` cycle, and read data is valid in that cycle. With a memory that acknowledges one cycle after the request, this is the second cycle after the request is presented.
- R10: Write-data lanes whose enable bit is 0 are driven as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | Byte order: 0 little, 1 big; sampled with each request |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_rdata | output | 32 | Right-aligned, zero-extended read data, valid with cpu_ready |
| cpu_misalign | output | 1 | Request refused as misaligned |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write |
| mem_word_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Full word from memory, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge |

## Verification
The bench drives each request on a falling edge and samples the outputs on later falling edges.

A misaligned request shows `cpu_misalign` and `cpu_ready` on the same falling edge on which it is driven (zero cycles). The bench checks that edge, and then one edge later it checks that no memory request has appeared.

An aligned access passes through two registers before it completes: the capture register, then the memory model's acknowledge register. The bench therefore expects `cpu_ready` exactly two falling edges after the request is driven. It reads the data only on that edge, and it takes the enables, word address and lane data from what the memory model latched on the request edge.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } steer_state_e;
endpackage

// File: rtl/lane_sel.sv
// Decodes size and byte offset into lane enables and a misalign flag.
module lane_sel
  import lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] be,
  output logic             bad
);
  int n_b;
  int o;

  always_comb begin
    n_b = 1 << int'(size);
    o   = int'(off);
    bad = (size == SZ_RSVD) || (n_b > LANES) || ((o % n_b) != 0);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be[l] = !bad && (l >= o) && (l < o + n_b);
  end
endmodule

// File: rtl/lane_wr_place.sv
// Places right-aligned write data onto memory lanes per byte order.
module lane_wr_place
  import lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] wdata,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              big,
  output logic [DATA_W-1:0] lanes
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] b;
    always_comb begin
      int n_b;
      int o;
      int k;
      n_b = 1 << int'(size);
      o   = int'(off);
      k   = big ? (o + n_b - 1 - l) : (l - o);
      b   = '0;
      if ((l >= o) && (l < o + n_b) && (k >= 0) && (k < LANES))
        b = wdata[k*LANE_W +: LANE_W];
    end
    assign lanes[l*LANE_W +: LANE_W] = b;
  end
endmodule

// File: rtl/lane_rd_extract.sv
// Picks requested bytes out of a full word, right-aligns, zero-extends.
module lane_rd_extract
  import lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] lanes,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              big,
  output logic [DATA_W-1:0] data
);
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [LANE_W-1:0] b;
    always_comb begin
      int n_b;
      int o;
      int src;
      n_b = 1 << int'(size);
      o   = int'(off);
      src = big ? (o + n_b - 1 - k) : (o + k);
      b   = '0;
      if ((k < n_b) && (src >= 0) && (src < LANES))
        b = lanes[src*LANE_W +: LANE_W];
    end
    assign data[k*LANE_W +: LANE_W] = b;
  end
endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W   = $clog2(LANES),
  localparam int DATA_W  = LANES * LANE_W,
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_big_endian,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic               cpu_we,
  input  logic [1:0]         cpu_size,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_misalign,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_word_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack
);
  steer_state_e st;
  acc_size_e    req_size;
  logic [OFF_W-1:0] req_off;

  logic [LANES-1:0]   be_c;
  logic               bad_c;
  logic [DATA_W-1:0]  lanes_c;
  logic [DATA_W-1:0]  rd_c;

  logic               r_we, r_big;
  acc_size_e          r_size;
  logic [OFF_W-1:0]   r_off;
  logic [WADDR_W-1:0] r_waddr;
  logic [LANES-1:0]   r_be;
  logic [DATA_W-1:0]  r_wdata;

  logic idle, accept, done;

  assign req_size = acc_size_e'(cpu_size);
  assign req_off  = cpu_addr[OFF_W-1:0];

  lane_sel #(.LANES(LANES)) u_sel (
    .size(req_size), .off(req_off), .be(be_c), .bad(bad_c)
  );

  lane_wr_place #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .wdata(cpu_wdata), .size(req_size), .off(req_off),
    .big(cfg_big_endian), .lanes(lanes_c)
  );

  lane_rd_extract #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .lanes(mem_rdata), .size(r_size), .off(r_off),
    .big(r_big), .data(rd_c)
  );

  assign idle   = (st == ST_IDLE);
  assign accept = idle && cpu_valid && !bad_c;
  assign done   = (st == ST_BUSY) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      r_we    <= 1'b0;
      r_big   <= 1'b0;
      r_size  <= SZ_BYTE;
      r_off   <= '0;
      r_waddr <= '0;
      r_be    <= '0;
      r_wdata <= '0;
    end else if (accept) begin
      st      <= ST_BUSY;
      r_we    <= cpu_we;
      r_big   <= cfg_big_endian;
      r_size  <= req_size;
      r_off   <= req_off;
      r_waddr <= cpu_addr[ADDR_W-1:OFF_W];
      r_be    <= be_c;
      r_wdata <= cpu_we ? lanes_c : '0;
    end else if (done) begin
      st      <= ST_IDLE;
      r_be    <= '0;
      r_wdata <= '0;
    end
  end

  assign mem_req       = (st == ST_BUSY);
  assign mem_we        = r_we;
  assign mem_word_addr = r_waddr;
  assign mem_be        = r_be;
  assign mem_wdata     = r_wdata;

  assign cpu_misalign = idle && cpu_valid && bad_c;
  assign cpu_ready    = cpu_misalign || done;
  assign cpu_rdata    = (done && !r_we) ? rd_c : '0;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int WADDR_W = 14,
  parameter int LANES   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_ready,
  input logic               cpu_misalign,
  input logic               mem_req,
  input logic [WADDR_W-1:0] mem_word_addr,
  input logic [LANES-1:0]   mem_be,
  input logic               mem_ack
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_word_addr) && $stable(mem_be))); // R2
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req); // R2
  AST_IDLE_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (mem_be == '0)); // R1
  AST_REQ_HAS_BE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != '0)); // R3
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                 || $countones(mem_be) == 4)); // R7
  AST_MISALIGN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_misalign |-> (!mem_req && cpu_ready)); // R8
  AST_MISALIGN_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_misalign |=> !mem_req); // R8
  AST_READY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_misalign) |-> (mem_ack && mem_req)); // R9
endmodule

bind lane_steer_top lane_steer_chk #(.WADDR_W(WADDR_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_misalign(cpu_misalign),
  .mem_req(mem_req), .mem_word_addr(mem_word_addr), .mem_be(mem_be),
  .mem_ack(mem_ack)
);

// File: tb/lane_steer_top_tb_top.sv
`timescale 1ns/1ps
module lane_steer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'b00;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_misalign;
  logic        mem_req, mem_we;
  logic [13:0] mem_word_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  mbyte [0:63];
  logic [3:0]  last_be;
  logic [31:0] last_wd;
  logic [13:0] last_wa;
  int          wr_cnt = 0;

  always #5 clk = ~clk;

  lane_steer_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_misalign(cpu_misalign),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word_addr(mem_word_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  // Memory model: acknowledge one cycle after the request is seen.
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      for (int l = 0; l < 4; l++) begin
        mem_rdata[l*8 +: 8] <= mbyte[mem_word_addr[3:0]*4 + l];
        if (mem_we && mem_be[l]) mbyte[mem_word_addr[3:0]*4 + l] <= mem_wdata[l*8 +: 8];
      end
      last_be <= mem_be;
      last_wd <= mem_wdata;
      last_wa <= mem_word_addr;
      if (mem_we) wr_cnt <= wr_cnt + 1;
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic mis, output int lat);
    bit done = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    lat = 0; rd = '0; mis = 1'b0;
    #1;
    while (!done) begin
      if (cpu_ready) begin
        rd = cpu_rdata; mis = cpu_misalign; done = 1;
      end else begin
        @(negedge clk); lat++;
        if (lat > 40) done = 1;
      end
    end
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mem_req in reset", {31'b0, mem_req}, 32'h0);
    chk("R1 cpu_ready in reset", {31'b0, cpu_ready}, 32'h0);
    chk("R1 mem_be in reset", {28'b0, mem_be}, 32'h0);
  endtask

  task automatic t_le_writes();
    logic [31:0] rd; logic mis; int lat;
    cfg_big_endian = 1'b0;
    access(1'b1, 2'b00, 16'h0005, 32'h0000_00AB, rd, mis, lat);
    chk("R3 byte be", {28'b0, last_be}, 32'h2);
    chk("R10 byte lanes", last_wd, 32'h0000_AB00);
    chk("R2 word addr 0x05", {18'b0, last_wa}, 32'h1);
    chk("R9 write latency", lat, 2);
    access(1'b1, 2'b01, 16'h0006, 32'h0000_1234, rd, mis, lat);
    chk("R3 half be", {28'b0, last_be}, 32'hC);
    chk("R3 half lanes", last_wd, 32'h1234_0000);
  endtask

  task automatic t_be_writes();
    logic [31:0] rd; logic mis; int lat;
    cfg_big_endian = 1'b1;
    access(1'b1, 2'b01, 16'h000A, 32'h0000_1234, rd, mis, lat);
    chk("R4 half be", {28'b0, last_be}, 32'hC);
    chk("R4 half lanes", last_wd, 32'h3412_0000);
    access(1'b1, 2'b00, 16'h000F, 32'h0000_005A, rd, mis, lat);
    chk("R4 byte lanes", last_wd, 32'h5A00_0000);
    chk("R2 word addr 0x0F", {18'b0, last_wa}, 32'h3);
    access(1'b0, 2'b01, 16'h000A, 32'h0, rd, mis, lat);
    chk("R6 half readback", rd, 32'h0000_1234);
    cfg_big_endian = 1'b0;
    access(1'b0, 2'b01, 16'h000A, 32'h0, rd, mis, lat);
    chk("R5 half readback other order", rd, 32'h0000_3412);
  endtask

  task automatic t_reads();
    logic [31:0] rd; logic mis; int lat;
    @(negedge clk);
    mbyte[12] = 8'h11; mbyte[13] = 8'h22; mbyte[14] = 8'h33; mbyte[15] = 8'h44;
    cfg_big_endian = 1'b0;
    access(1'b0, 2'b00, 16'h000D, 32'h0, rd, mis, lat);
    chk("R5 byte read", rd, 32'h0000_0022);
    chk("R9 read latency", lat, 2);
    access(1'b0, 2'b01, 16'h000E, 32'h0, rd, mis, lat);
    chk("R5 half read", rd, 32'h0000_4433);
    access(1'b0, 2'b10, 16'h000C, 32'h0, rd, mis, lat);
    chk("R7 LE word read", rd, 32'h4433_2211);
    cfg_big_endian = 1'b1;
    access(1'b0, 2'b01, 16'h000E, 32'h0, rd, mis, lat);
    chk("R6 half read", rd, 32'h0000_3344);
    access(1'b0, 2'b00, 16'h000C, 32'h0, rd, mis, lat);
    chk("R6 byte read", rd, 32'h0000_0011);
    access(1'b0, 2'b10, 16'h000C, 32'h0, rd, mis, lat);
    chk("R7 BE word read", rd, 32'h1122_3344);
  endtask

  task automatic t_words();
    logic [31:0] rd; logic mis; int lat;
    cfg_big_endian = 1'b0;
    access(1'b1, 2'b10, 16'h0010, 32'hDEAD_BEEF, rd, mis, lat);
    chk("R7 LE word be", {28'b0, last_be}, 32'hF);
    chk("R7 LE word lanes", last_wd, 32'hDEAD_BEEF);
    cfg_big_endian = 1'b1;
    access(1'b1, 2'b10, 16'h0014, 32'hDEAD_BEEF, rd, mis, lat);
    chk("R7 BE word lanes", last_wd, 32'hEFBE_ADDE);
    access(1'b0, 2'b00, 16'h0014, 32'h0, rd, mis, lat);
    chk("R6 BE first byte is MSB", rd, 32'h0000_00DE);
  endtask

  task automatic t_misalign();
    logic [31:0] rd; logic mis; int lat; int w0;
    logic [1:0] szs [3] = '{2'b01, 2'b10, 2'b11};
    logic [15:0] adr [3] = '{16'h0003, 16'h0006, 16'h0000};
    cfg_big_endian = 1'b0;
    for (int i = 0; i < 3; i++) begin
      w0 = wr_cnt;
      access(1'b1, szs[i], adr[i], 32'hFFFF_FFFF, rd, mis, lat);
      chk("R8 misalign flag", {31'b0, mis}, 32'h1);
      chk("R8 same-cycle ready", lat, 0);
      chk("R8 no memory request", {31'b0, mem_req}, 32'h0);
      @(negedge clk);
      chk("R8 memory untouched", wr_cnt, w0);
    end
    access(1'b0, 2'b01, 16'h0002, 32'h0, rd, mis, lat);
    chk("R8 aligned half accepted", {31'b0, mis}, 32'h0);
    access(1'b0, 2'b10, 16'h0000, 32'h0, rd, mis, lat);
    chk("R8 word 0 unchanged", rd, 32'h0000_0000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mbyte[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_le_writes();
    t_be_writes();
    t_reads();
    t_words();
    t_misalign();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule